// File: doc/BRIEF.md
# Load/Store Alignment Checker and Splitter

This unit sits between a load/store pipeline and a 64-bit memory port. Each accepted access carries an address, a size of 1, 2, 4 or 8 bytes, a class flag (integer or floating point), a store flag with write data, and a policy input. The policy selects one of two behaviours for misaligned floating-point work:

- **Hardware-fix policy:** misaligned floating-point accesses are repaired in hardware.
- **Trap policy:** misaligned floating-point accesses raise an alignment exception.

An access that is naturally aligned leaves as one memory request. An access that is not aligned either leaves as two aligned requests or raises an exception and leaves as no request at all. For each request the unit produces the doubleword address, the byte enables and the write data steered onto byte lanes.

Whether the unit splits or traps depends on three things: the data class, the policy, and whether the access runs past the end of a 4 KB page. A running count of taken exceptions is kept and can be cleared by a command input. While the second half of a split is pending, the request input is stalled through a valid/ready handshake.

Top module: `lsa_align_unit`

## Requirements
- R1: An access of size s (`req_size` 0,1,2,3 = 1,2,4,8 bytes) is naturally aligned when the low log2(s) address bits are zero. A byte access is therefore never misaligned. An aligned access produces exactly one request in the cycle after acceptance, with no exception.
- R2: With `trap_mode`=1, a floating-point access of 4 or 8 bytes whose address is not a multiple of 4 raises `exc_flag` for one cycle and produces no `mem_valid` strobe.
- R3: With `trap_mode`=0, a floating-point 8-byte access at an address that is not a multiple of 8 is misaligned. If it stays within one 4 KB page, it is completed as two requests.
- R4: With `trap_mode`=0, a misaligned floating-point access of 4 or 8 bytes that crosses a 4 KB page raises the exception and issues no request. A page is crossed when `addr[11:0] + s - 1` exceeds 0xFFF.
- R5: A misaligned integer access never traps in either policy, even across a page, and is always split into two requests. A floating-point access of 1 or 2 bytes follows the integer rules.
- R6: A split issues exactly two requests on consecutive cycles. The first covers the bytes from the address up to the next multiple of s. The second covers the rest. Each request carries `mem_addr` with bits [2:0] zero and `mem_be` bit k set for each byte of that half whose address modulo 8 is k.
- R7: Byte i of `req_wdata` (bits 8i+7:8i) appears on lane (addr+i) mod 8 of `mem_wdata`. `mem_we` equals the store flag of the access.
- R8: `exc_count` increments by one for each trapping access. `cnt_clr` sets it to zero at the next edge, and takes priority over an increment at the same edge.
- R9: After accepting an access that splits, `req_ready` is low for exactly one cycle, during which the second half is issued. It stays high for accesses that do not split.
- R10: After reset, `mem_valid` and `exc_flag` are low, `exc_count` is zero and `req_ready` is high.
- R11: With `trap_mode`=1, a floating-point 8-byte access at an address that is 4 modulo 8 does not trap and is split into two requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Unit can accept an access this cycle |
| req_addr | input | AW | Byte address of the access |
| req_size | input | 2 | log2 of access size in bytes |
| req_fp | input | 1 | 1 = floating-point class, 0 = integer |
| req_store | input | 1 | 1 = store, 0 = load |
| req_wdata | input | 64 | Store data, byte 0 in bits 7:0 |
| trap_mode | input | 1 | 1 = trap policy, 0 = hardware-fix policy |
| cnt_clr | input | 1 | Clear the exception count |
| mem_valid | output | 1 | Memory request strobe |
| mem_addr | output | AW | Doubleword-aligned request address |
| mem_be | output | 8 | Byte enables of the request |
| mem_we | output | 1 | Write request |
| mem_wdata | output | 64 | Lane-steered write data |
| exc_flag | output | 1 | Alignment exception pulse |
| exc_count | output | CW | Exceptions taken since last clear |

## Verification
The assertions assume the following about the inputs:

- Every input is driven with known values in step with the clock.
- A request, once raised, is held until `req_ready` accepts it, so each accepted access is decoded from one stable set of fields.
- The memory port never pushes back.

The stimulus keeps within these assumptions in several ways. It changes inputs only on falling edges and waits out the stall cycle of a split before presenting the next access. Random addresses are biased toward the last eight bytes of a page, so that page-crossing and in-page misaligned cases both occur under each policy and data class.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  localparam int DATA_W  = 64;
  localparam int LANES   = DATA_W / 8;
  localparam int OFF_W   = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } size_e;

  // number of bytes carried by a size code
  function automatic logic [OFF_W:0] bytes_of(input logic [1:0] sz);
    return (OFF_W+1)'(1) << sz;
  endfunction
endpackage

// File: rtl/lsa_decode.sv
module lsa_decode
  import lsa_pkg::*;
#(
  parameter int AW        = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic [AW-1:0]  addr,
  input  logic [1:0]     size,
  input  logic           fp,
  input  logic           trap_mode,
  output logic           trap,
  output logic           split,
  output logic [OFF_W:0] first_len,
  output logic [OFF_W:0] second_len,
  output logic [AW-1:0]  second_addr
);
  logic [OFF_W:0]     nbytes;
  logic [OFF_W-1:0]   low;
  logic               nat_mis;
  logic               crosses_page;
  logic               fp_wide;
  logic [PAGE_BITS:0] last_byte;

  always_comb begin
    nbytes       = bytes_of(size);
    low          = addr[OFF_W-1:0] & (nbytes[OFF_W-1:0] - 1'b1);
    nat_mis      = (low != '0);
    last_byte    = {1'b0, addr[PAGE_BITS-1:0]} + (PAGE_BITS+1)'(nbytes - 1'b1);
    crosses_page = last_byte[PAGE_BITS];
    fp_wide      = fp && (size == SZ_WORD || size == SZ_DBL);
    if (!fp_wide)
      trap = 1'b0;
    else if (trap_mode)
      trap = (addr[1:0] != 2'b00);
    else
      trap = nat_mis && crosses_page;
    split       = nat_mis && !trap;
    first_len   = split ? (nbytes - {1'b0, low}) : nbytes;
    second_len  = nbytes - first_len;
    second_addr = addr + AW'(first_len);
  end
endmodule

// File: rtl/lsa_lanes.sv
module lsa_lanes
  import lsa_pkg::*;
(
  input  logic [OFF_W-1:0] start,
  input  logic [OFF_W:0]   len,
  output logic [LANES-1:0] be
);
  logic [OFF_W:0] stop;
  assign stop = {1'b0, start} + len;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    localparam logic [OFF_W:0] JV = (OFF_W+1)'(j);
    assign be[j] = (JV >= {1'b0, start}) && (JV < stop);
  end
endmodule

// File: rtl/lsa_exc_count.sv
module lsa_exc_count #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clr)
      count <= '0;
    else if (inc)
      count <= count + 1'b1;
  end
endmodule

// File: rtl/lsa_align_unit.sv
module lsa_align_unit
  import lsa_pkg::*;
#(
  parameter int AW        = 32,
  parameter int PAGE_BITS = 12,
  parameter int CW        = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_fp,
  input  logic              req_store,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              trap_mode,
  input  logic              cnt_clr,
  output logic              mem_valid,
  output logic [AW-1:0]     mem_addr,
  output logic [LANES-1:0]  mem_be,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              exc_flag,
  output logic [CW-1:0]     exc_count
);
  localparam int HALVES = 2;

  logic              accept;
  logic              trap;
  logic              split;
  logic [OFF_W:0]    first_len;
  logic [OFF_W:0]    second_len;
  logic [AW-1:0]     second_addr;
  logic [2*DATA_W-1:0] rot_wide;
  logic [DATA_W-1:0] steered;

  logic [OFF_W-1:0]  half_start [HALVES];
  logic [OFF_W:0]    half_len   [HALVES];
  logic [LANES-1:0]  half_be    [HALVES];

  logic              pend_q;
  logic [AW-1:0]     pend_addr_q;
  logic [LANES-1:0]  pend_be_q;

  assign req_ready = !pend_q;
  assign accept    = req_valid && req_ready;

  lsa_decode #(.AW(AW), .PAGE_BITS(PAGE_BITS)) dec_i (
    .addr        (req_addr),
    .size        (req_size),
    .fp          (req_fp),
    .trap_mode   (trap_mode),
    .trap        (trap),
    .split       (split),
    .first_len   (first_len),
    .second_len  (second_len),
    .second_addr (second_addr)
  );

  // rotate item bytes onto lanes by the low address bits
  assign rot_wide = {req_wdata, req_wdata} << (req_addr[OFF_W-1:0] * 8);
  assign steered  = rot_wide[2*DATA_W-1:DATA_W];

  assign half_start[0] = req_addr[OFF_W-1:0];
  assign half_len[0]   = first_len;
  assign half_start[1] = second_addr[OFF_W-1:0];
  assign half_len[1]   = second_len;

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    lsa_lanes lanes_i (
      .start (half_start[h]),
      .len   (half_len[h]),
      .be    (half_be[h])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_valid   <= 1'b0;
      mem_addr    <= '0;
      mem_be      <= '0;
      mem_we      <= 1'b0;
      mem_wdata   <= '0;
      exc_flag    <= 1'b0;
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
      pend_be_q   <= '0;
    end else begin
      mem_valid <= 1'b0;
      exc_flag  <= 1'b0;
      if (pend_q) begin
        mem_valid <= 1'b1;
        mem_addr  <= pend_addr_q;
        mem_be    <= pend_be_q;
        pend_q    <= 1'b0;
      end else if (accept) begin
        if (trap) begin
          exc_flag <= 1'b1;
        end else begin
          mem_valid <= 1'b1;
          mem_addr  <= {req_addr[AW-1:OFF_W], {OFF_W{1'b0}}};
          mem_be    <= half_be[0];
          mem_we    <= req_store;
          mem_wdata <= steered;
        end
        if (split) begin
          pend_q      <= 1'b1;
          pend_addr_q <= {second_addr[AW-1:OFF_W], {OFF_W{1'b0}}};
          pend_be_q   <= half_be[1];
        end
      end
    end
  end

  lsa_exc_count #(.CW(CW)) cnt_i (
    .clk   (clk),
    .rst   (rst),
    .clr   (cnt_clr),
    .inc   (accept && trap),
    .count (exc_count)
  );
endmodule

// File: rtl/lsa_align_chk.sv
module lsa_align_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic [1:0]    req_size,
  input logic          req_fp,
  input logic          cnt_clr,
  input logic          mem_valid,
  input logic [7:0]    mem_be,
  input logic          exc_flag,
  input logic [CW-1:0] exc_count
);
  p_trap_no_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    exc_flag |-> !mem_valid);

  p_byte_never_traps_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_size == 2'd0) |=> !exc_flag);

  p_int_never_traps_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_fp) |=> !exc_flag);

  p_second_half_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !req_ready) |=> mem_valid);

  p_enables_present_r6: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> (mem_be != 8'h00));

  p_stall_one_cycle_r9: assert property (@(posedge clk) disable iff (rst)
    !req_ready |=> req_ready);

  p_count_step_r8: assert property (@(posedge clk) disable iff (rst)
    (exc_flag && !$past(cnt_clr)) |-> (exc_count == CW'($past(exc_count) + 1'b1)));

  p_count_clear_r8: assert property (@(posedge clk) disable iff (rst)
    cnt_clr |=> (exc_count == '0));
endmodule

bind lsa_align_unit lsa_align_chk #(.CW(CW)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_size  (req_size),
  .req_fp    (req_fp),
  .cnt_clr   (cnt_clr),
  .mem_valid (mem_valid),
  .mem_be    (mem_be),
  .exc_flag  (exc_flag),
  .exc_count (exc_count)
);

// File: tb/lsa_align_unit_tb.sv
module lsa_align_unit_tb_top;
  localparam int AW = 32;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid;
  logic          req_ready;
  logic [AW-1:0] req_addr;
  logic [1:0]    req_size;
  logic          req_fp;
  logic          req_store;
  logic [63:0]   req_wdata;
  logic          trap_mode;
  logic          cnt_clr;
  logic          mem_valid;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_be;
  logic          mem_we;
  logic [63:0]   mem_wdata;
  logic          exc_flag;
  logic [CW-1:0] exc_count;

  int n_chk  = 0;
  int n_fail = 0;
  int exp_cnt = 0;

  always #5 clk = ~clk;

  lsa_align_unit #(.AW(AW), .CW(CW)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_fp(req_fp),
    .req_store(req_store), .req_wdata(req_wdata), .trap_mode(trap_mode),
    .cnt_clr(cnt_clr), .mem_valid(mem_valid), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .exc_flag(exc_flag), .exc_count(exc_count)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] bmask(input logic [7:0] be);
    logic [63:0] m = '0;
    for (int k = 0; k < 8; k++) if (be[k]) m[k*8 +: 8] = 8'hFF;
    return m;
  endfunction

  function automatic bit ref_trap(input logic [31:0] a, input logic [1:0] sz,
                                  input bit fp, input bit mode);
    int n = 1 << sz;
    if (!(fp && sz >= 2)) return 1'b0;
    if (mode) return (a % 4) != 0;
    return ((a % n) != 0) && ((a % 4096) + n - 1 >= 4096);
  endfunction

  task automatic access(input logic [31:0] a, input logic [1:0] sz, input bit fp,
                        input bit st, input bit mode, input logic [63:0] wd,
                        input bit clr_too);
    int n = 1 << sz;
    bit trap = ref_trap(a, sz, fp, mode);
    bit mis = (a % n) != 0;
    bit split = mis && !trap;
    logic [31:0] bnd = split ? (a / n) * n + n : a + n;
    logic [7:0] be0 = '0;
    logic [7:0] be1 = '0;
    logic [63:0] ed = '0;
    string tag;
    for (int i = 0; i < n; i++) begin
      logic [31:0] ba = a + i;
      if (ba < bnd) be0[ba % 8] = 1'b1; else be1[ba % 8] = 1'b1;
      ed[(ba % 8)*8 +: 8] = wd[i*8 +: 8];
    end
    if (trap) tag = mode ? "R2" : "R4";
    else if (!split) tag = "R1";
    else if (!(fp && sz >= 2)) tag = "R5";
    else if (mode) tag = "R11";
    else tag = "R3";
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = sz; req_fp = fp;
    req_store = st; req_wdata = wd; trap_mode = mode; cnt_clr = clr_too;
    @(negedge clk);
    req_valid = 1'b0; cnt_clr = 1'b0;
    if (clr_too) exp_cnt = 0; else if (trap) exp_cnt++;
    chk({tag, " strobe"}, 64'(mem_valid), 64'(!trap));
    chk({tag, " exception"}, 64'(exc_flag), 64'(trap));
    chk("R8 count", 64'(exc_count), 64'(exp_cnt[CW-1:0]));
    chk("R9 ready", 64'(req_ready), 64'(!split));
    if (!trap) begin
      chk("R6 addr0", 64'(mem_addr), 64'(a & ~32'd7));
      chk("R6 be0", 64'(mem_be), 64'(be0));
      chk("R7 we", 64'(mem_we), 64'(st));
      chk("R7 data0", mem_wdata & bmask(be0), ed & bmask(be0));
    end
    if (split) begin
      @(negedge clk);
      chk("R6 second strobe", 64'(mem_valid), 64'd1);
      chk("R6 addr1", 64'(mem_addr), 64'(bnd & ~32'd7));
      chk("R6 be1", 64'(mem_be), 64'(be1));
      chk("R7 data1", mem_wdata & bmask(be1), ed & bmask(be1));
      chk("R9 ready back", 64'(req_ready), 64'd1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] ra;
    void'($urandom(32'd20240611));
    rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_size = '0; req_fp = 1'b0;
    req_store = 1'b0; req_wdata = '0; trap_mode = 1'b0; cnt_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 mem_valid", 64'(mem_valid), 64'd0);
    chk("R10 exc_flag", 64'(exc_flag), 64'd0);
    chk("R10 count", 64'(exc_count), 64'd0);
    chk("R10 ready", 64'(req_ready), 64'd1);

    // directed corner cases
    access(32'h0000_1003, 2'd0, 1'b0, 1'b1, 1'b0, 64'h1122_3344_5566_77AA, 1'b0); // R1 byte odd
    access(32'h0000_2008, 2'd3, 1'b1, 1'b1, 1'b1, 64'h0102_0304_0506_0708, 1'b0); // R1 aligned double
    access(32'h0000_3002, 2'd2, 1'b1, 1'b1, 1'b1, 64'hDEAD_BEEF_CAFE_F00D, 1'b0); // R2
    access(32'h0000_4004, 2'd3, 1'b1, 1'b1, 1'b0, 64'hA1A2_A3A4_A5A6_A7A8, 1'b0); // R3
    access(32'h0000_4FFC, 2'd3, 1'b1, 1'b1, 1'b0, 64'hB1B2_B3B4_B5B6_B7B8, 1'b0); // R4
    access(32'h0000_5FFE, 2'd2, 1'b0, 1'b1, 1'b0, 64'hC1C2_C3C4_C5C6_C7C8, 1'b0); // R5 page
    access(32'h0000_5FFF, 2'd3, 1'b0, 1'b1, 1'b1, 64'hD1D2_D3D4_D5D6_D7D8, 1'b0); // R5 trap mode
    access(32'h0000_6004, 2'd3, 1'b1, 1'b1, 1'b1, 64'hE1E2_E3E4_E5E6_E7E8, 1'b0); // R11
    access(32'h0000_7001, 2'd1, 1'b1, 1'b0, 1'b1, 64'h0000_0000_0000_BEEF, 1'b0); // R5 fp half
    access(32'h0000_7006, 2'd2, 1'b1, 1'b1, 1'b1, 64'h1, 1'b1);                   // R8 clear wins
    // R8 standalone clear
    @(negedge clk); cnt_clr = 1'b1;
    @(negedge clk); cnt_clr = 1'b0; exp_cnt = 0;
    chk("R8 cleared", 64'(exc_count), 64'd0);

    for (int t = 0; t < 400; t++) begin
      ra = $urandom;
      if (($urandom % 3) == 0) ra[11:0] = 12'hFF8 | 12'($urandom % 8);
      access(ra, 2'($urandom % 4), 1'($urandom % 2), 1'($urandom % 2),
             1'($urandom % 2), {$urandom, $urandom}, ($urandom % 50) == 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule